// File: doc/BRIEF.md
# Write Protection Command Gate

This block sits between the host write path and the page write controller of a parallel non-volatile memory. It inspects every host write strobe (address and data) for fixed multi-write command sequences. One sequence arms protection and also unlocks the writes that follow it in the same load window. The other sequence turns protection off. Writes that form part of a recognised sequence are swallowed, so they never reach the array. Those command addresses still accept ordinary data at any other time.

For each strobe the block returns a registered decision one cycle later. The decision is one of three outcomes: commit the write, swallow it as a command, or block it. A blocked write raises a dummy-cycle request. That request starts the program timer without storing data, so reads see a normal busy period. Protection state changes only when the program cycle that follows a completed sequence reports its end. Protection is off out of reset.

The command addresses and data bytes are parameters, and so are the sequence lengths. The load-window timeout comes from the page write controller. It closes both the current command attempt and any unlock.

Top module: `wp_cmd_gate`

## Requirements
- R1: Out of reset the protection flag is 0, and the decision valid, grant and dummy outputs are 0.
- R2: Every write strobe produces exactly one decision pulse in the cycle after the strobe. An ordinary write while unprotected is granted, with no dummy request.
- R3: A write that matches the next expected step of either command sequence is swallowed: the decision is valid with grant 0 and dummy 0. The default arm sequence is step 0 = data 0xAA at 0x5555, step 1 = data 0x55 at 0x2AAA, step 2 = data 0xA0 at 0x5555.
- R4: Completing the arm sequence does not change the protection flag at once. The flag becomes 1 in the cycle after the next program-done pulse.
- R5: While protected, an ordinary write outside an unlocked window is blocked: grant 0 and dummy 1.
- R6: After a completed sequence, ordinary writes are granted until the load window ends. The first ordinary write after the window end is treated under the current protection state.
- R7: The default disarm sequence is six writes: 0xAA at 0x5555, 0x55 at 0x2AAA, 0x80 at 0x5555, 0xAA at 0x5555, 0x55 at 0x2AAA, 0x20 at 0x5555. All six are swallowed, and protection drops at the next program-done pulse.
- R8: A write that fails to match the expected step returns the matcher to step 0. That write is judged as an ordinary write, and the sequence cannot be finished without starting over.
- R9: A load-window end abandons any partial sequence. A strobe in the same cycle as the window end is judged as the first write of a new window.
- R10: A write to a command address whose data does not match the expected step is an ordinary write.
- R11: Once set, protection stays set across further program-done pulses until a disarm sequence completes.
- R12: A program-done pulse with no completed sequence pending leaves the protection flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_stb_i | input | 1 | One-cycle host write strobe |
| wr_addr_i | input | AW | Write address |
| wr_data_i | input | DW | Write data |
| win_end_i | input | 1 | Byte-load window has expired |
| prog_done_i | input | 1 | Program cycle has finished |
| dec_vld_o | output | 1 | Decision pulse for the previous cycle's strobe |
| grant_o | output | 1 | Write may be committed |
| dummy_o | output | 1 | Blocked: start a program cycle that stores nothing |
| prot_o | output | 1 | Protection state flag |

## Verification
The bench aborts the arm sequence after every possible prefix with a stray write. A design that kept its partial progress would unlock a later write, and a design that dropped the stray write would return no decision for it. It sends a strobe in the same cycle as a window end, which catches a design that applies the clear after the match and loses the first step. It also checks the protection flag both before and after the program-done pulse, and sends extra program-done pulses. This catches a design that arms or disarms too early, or that toggles the flag on every completed program cycle. The disarm run shares its first two steps with the arm sequence, which exposes matchers that reset each other on a partial hit.

// File: rtl/wp_cmd_pkg.sv
package wp_cmd_pkg;
   localparam int DEF_AW = 17;
   localparam int DEF_DW = 8;

   // Step k occupies slot k, slot 0 in the least significant position.
   localparam logic [3*DEF_AW-1:0] DEF_ARM_ADDR = {17'h05555, 17'h02AAA, 17'h05555};
   localparam logic [3*DEF_DW-1:0] DEF_ARM_DATA = {8'hA0, 8'h55, 8'hAA};
   localparam logic [6*DEF_AW-1:0] DEF_DIS_ADDR = {17'h05555, 17'h02AAA, 17'h05555,
                                                  17'h05555, 17'h02AAA, 17'h05555};
   localparam logic [6*DEF_DW-1:0] DEF_DIS_DATA = {8'h20, 8'h55, 8'hAA,
                                                  8'h80, 8'h55, 8'hAA};

   typedef struct packed {
      logic vld;
      logic grant;
      logic dummy;
   } wp_dec_t;
endpackage

// File: rtl/wp_seq_match.sv
module wp_seq_match #(
   parameter int AW = 17,
   parameter int DW = 8,
   parameter int LEN = 3,
   parameter logic [LEN*AW-1:0] ADDRS = '0,
   parameter logic [LEN*DW-1:0] DATAS = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          stb_i,
   input  logic [AW-1:0] addr_i,
   input  logic [DW-1:0] data_i,
   input  logic          win_end_i,
   input  logic          clr_i,
   output logic          hit_o,
   output logic          done_o
);
   localparam int IW = (LEN > 1) ? $clog2(LEN) : 1;

   if (LEN < 1) begin : g_bad_len
      $error("wp_seq_match: LEN must be at least 1");
   end

   logic [AW-1:0] slot_a [LEN];
   logic [DW-1:0] slot_d [LEN];

   for (genvar k = 0; k < LEN; k++) begin : g_slot
      assign slot_a[k] = ADDRS[k*AW +: AW];
      assign slot_d[k] = DATAS[k*DW +: DW];
   end

   if (LEN == 1) begin : g_single
      // One-write command: no progress register needed.
      assign hit_o  = stb_i && (addr_i == slot_a[0]) && (data_i == slot_d[0]);
      assign done_o = hit_o;
   end else begin : g_multi
      logic [IW-1:0] idx_q;
      logic [IW-1:0] eff;

      // A window end in the same cycle restarts matching at step 0.
      assign eff    = win_end_i ? '0 : idx_q;
      assign hit_o  = stb_i && (addr_i == slot_a[eff]) && (data_i == slot_d[eff]);
      assign done_o = hit_o && (eff == IW'(LEN - 1));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            idx_q <= '0;
         end else if (clr_i) begin
            idx_q <= '0;
         end else if (stb_i) begin
            idx_q <= (hit_o && !done_o) ? eff + IW'(1) : '0;
         end else if (win_end_i) begin
            idx_q <= '0;
         end
      end

      a_r8_miss_restarts : assert property (@(posedge clk) disable iff (!rst_n)
         (stb_i && !hit_o) |=> (idx_q == '0));

      a_r9_window_clears : assert property (@(posedge clk) disable iff (!rst_n)
         (win_end_i && !stb_i) |=> (idx_q == '0));

      a_r3_index_in_range : assert property (@(posedge clk) disable iff (!rst_n)
         idx_q < IW'(LEN));
   end
endmodule

// File: rtl/wp_policy.sv
module wp_policy
   import wp_cmd_pkg::*;
#(
   parameter bit UNLOCK_ON_DISARM = 1'b1
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    stb_i,
   input  logic    arm_hit_i,
   input  logic    arm_done_i,
   input  logic    dis_hit_i,
   input  logic    dis_done_i,
   input  logic    win_end_i,
   input  logic    prog_done_i,
   output wp_dec_t dec_o,
   output logic    prot_o
);
   logic    prot_q, pend_arm_q, pend_dis_q, unlock_q;
   logic    unlock_eff, ordinary, seq_done;
   wp_dec_t dec_n, dec_q;

   assign unlock_eff = unlock_q && !win_end_i;
   assign ordinary   = stb_i && !arm_hit_i && !dis_hit_i;

   if (UNLOCK_ON_DISARM) begin : g_unlock_both
      assign seq_done = arm_done_i || dis_done_i;
   end else begin : g_unlock_arm
      assign seq_done = arm_done_i;
   end

   always_comb begin
      dec_n.vld   = stb_i;
      dec_n.grant = ordinary && (!prot_q || unlock_eff);
      dec_n.dummy = ordinary && prot_q && !unlock_eff;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prot_q     <= 1'b0;
         pend_arm_q <= 1'b0;
         pend_dis_q <= 1'b0;
         unlock_q   <= 1'b0;
         dec_q      <= '0;
      end else begin
         dec_q <= dec_n;

         if (seq_done)       unlock_q <= 1'b1;
         else if (win_end_i) unlock_q <= 1'b0;

         if (prog_done_i) begin
            if (pend_arm_q)      prot_q <= 1'b1;
            else if (pend_dis_q) prot_q <= 1'b0;
         end

         if (arm_done_i) begin
            pend_arm_q <= 1'b1;
            pend_dis_q <= 1'b0;
         end else if (dis_done_i) begin
            pend_arm_q <= 1'b0;
            pend_dis_q <= 1'b1;
         end else if (prog_done_i) begin
            pend_arm_q <= 1'b0;
            pend_dis_q <= 1'b0;
         end
      end
   end

   assign dec_o  = dec_q;
   assign prot_o = prot_q;

   a_r2_one_decision_per_strobe : assert property (@(posedge clk) disable iff (!rst_n)
      stb_i |=> dec_q.vld);

   a_r2_no_spurious_decision : assert property (@(posedge clk) disable iff (!rst_n)
      !stb_i |=> !dec_q.vld);

   a_r5_grant_dummy_exclusive : assert property (@(posedge clk) disable iff (!rst_n)
      !(dec_q.grant && dec_q.dummy));

   a_r11_prot_moves_on_prog_only : assert property (@(posedge clk) disable iff (!rst_n)
      !prog_done_i |=> $stable(prot_q));

   a_r12_idle_prog_keeps_prot : assert property (@(posedge clk) disable iff (!rst_n)
      (prog_done_i && !pend_arm_q && !pend_dis_q) |=> $stable(prot_q));
endmodule

// File: rtl/wp_cmd_gate.sv
module wp_cmd_gate
   import wp_cmd_pkg::*;
#(
   parameter int AW = DEF_AW,
   parameter int DW = DEF_DW,
   parameter int ARM_LEN = 3,
   parameter int DIS_LEN = 6,
   parameter logic [ARM_LEN*AW-1:0] ARM_ADDR = DEF_ARM_ADDR,
   parameter logic [ARM_LEN*DW-1:0] ARM_DATA = DEF_ARM_DATA,
   parameter logic [DIS_LEN*AW-1:0] DIS_ADDR = DEF_DIS_ADDR,
   parameter logic [DIS_LEN*DW-1:0] DIS_DATA = DEF_DIS_DATA,
   parameter bit UNLOCK_ON_DISARM = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_stb_i,
   input  logic [AW-1:0] wr_addr_i,
   input  logic [DW-1:0] wr_data_i,
   input  logic          win_end_i,
   input  logic          prog_done_i,
   output logic          dec_vld_o,
   output logic          grant_o,
   output logic          dummy_o,
   output logic          prot_o
);
   if (AW < 1 || DW < 1) begin : g_bad_width
      $error("wp_cmd_gate: AW and DW must be positive");
   end
   if (ARM_LEN < 1 || DIS_LEN < 1) begin : g_bad_len
      $error("wp_cmd_gate: sequence lengths must be positive");
   end

   logic    arm_hit, arm_done, dis_hit, dis_done;
   wp_dec_t dec;

   wp_seq_match #(
      .AW(AW), .DW(DW), .LEN(ARM_LEN), .ADDRS(ARM_ADDR), .DATAS(ARM_DATA)
   ) u_arm (
      .clk(clk), .rst_n(rst_n), .stb_i(wr_stb_i), .addr_i(wr_addr_i),
      .data_i(wr_data_i), .win_end_i(win_end_i), .clr_i(dis_done),
      .hit_o(arm_hit), .done_o(arm_done)
   );

   wp_seq_match #(
      .AW(AW), .DW(DW), .LEN(DIS_LEN), .ADDRS(DIS_ADDR), .DATAS(DIS_DATA)
   ) u_dis (
      .clk(clk), .rst_n(rst_n), .stb_i(wr_stb_i), .addr_i(wr_addr_i),
      .data_i(wr_data_i), .win_end_i(win_end_i), .clr_i(arm_done),
      .hit_o(dis_hit), .done_o(dis_done)
   );

   wp_policy #(
      .UNLOCK_ON_DISARM(UNLOCK_ON_DISARM)
   ) u_pol (
      .clk(clk), .rst_n(rst_n), .stb_i(wr_stb_i),
      .arm_hit_i(arm_hit), .arm_done_i(arm_done),
      .dis_hit_i(dis_hit), .dis_done_i(dis_done),
      .win_end_i(win_end_i), .prog_done_i(prog_done_i),
      .dec_o(dec), .prot_o(prot_o)
   );

   assign dec_vld_o = dec.vld;
   assign grant_o   = dec.grant;
   assign dummy_o   = dec.dummy;

   a_r3_command_never_granted : assert property (@(posedge clk) disable iff (!rst_n)
      (arm_hit || dis_hit) |=> (!grant_o && !dummy_o));

   a_r5_dummy_only_when_protected : assert property (@(posedge clk) disable iff (!rst_n)
      dummy_o |-> $past(prot_o));
endmodule

// File: tb/wp_cmd_gate_tb.sv
module wp_cmd_gate_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        stb = 1'b0;
   logic [16:0] addr = '0;
   logic [7:0]  data = '0;
   logic        win = 1'b0;
   logic        prog = 1'b0;
   logic        vld, grant, dummy, prot;
   int          checks = 0;
   int          fails = 0;
   bit          finished = 1'b0;

   always #10 clk = ~clk;

   wp_cmd_gate u_dut (
      .clk(clk), .rst_n(rst_n), .wr_stb_i(stb), .wr_addr_i(addr), .wr_data_i(data),
      .win_end_i(win), .prog_done_i(prog), .dec_vld_o(vld), .grant_o(grant),
      .dummy_o(dummy), .prot_o(prot)
   );

   // Default command values, step order.
   logic [16:0] arm_a [3] = '{17'h05555, 17'h02AAA, 17'h05555};
   logic [7:0]  arm_d [3] = '{8'hAA, 8'h55, 8'hA0};
   logic [16:0] dis_a [6] = '{17'h05555, 17'h02AAA, 17'h05555, 17'h05555, 17'h02AAA, 17'h05555};
   logic [7:0]  dis_d [6] = '{8'hAA, 8'h55, 8'h80, 8'hAA, 8'h55, 8'h20};

   task automatic chk(input string rq, input string what, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%0b expected=%0b", rq, what, act, exp);
      end
   endtask

   // kind: 0 swallowed, 1 granted, 2 blocked
   task automatic wr(input logic [16:0] a, input logic [7:0] d, input logic we,
                     input int kind, input string rq);
      @(negedge clk);
      stb = 1'b1; addr = a; data = d; win = we;
      @(negedge clk);
      stb = 1'b0; win = 1'b0;
      chk(rq, "vld", vld, 1'b1);
      chk(rq, "grant", grant, kind == 1);
      chk(rq, "dummy", dummy, kind == 2);
   endtask

   task automatic win_pulse();
      @(negedge clk); win = 1'b1;
      @(negedge clk); win = 1'b0;
   endtask

   task automatic prog_pulse();
      @(negedge clk); prog = 1'b1;
      @(negedge clk); prog = 1'b0;
   endtask

   task automatic arm_seq(input string rq);
      for (int k = 0; k < 3; k++) wr(arm_a[k], arm_d[k], 1'b0, 0, rq);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1", "prot", prot, 1'b0);
      chk("R1", "vld", vld, 1'b0);
      chk("R1", "grant", grant, 1'b0);
      chk("R1", "dummy", dummy, 1'b0);

      // R2 ordinary writes while unprotected
      for (int i = 0; i < 8; i++)
         wr(17'((i * 4099 + 17) & 17'h1FFFF), 8'(i * 37), 1'b0, 1, "R2");
      @(negedge clk);
      chk("R2", "idle vld", vld, 1'b0);

      // R12 program-done with nothing pending
      prog_pulse();
      chk("R12", "prot", prot, 1'b0);

      // R3 / R4 arm sequence
      arm_seq("R3");
      chk("R4", "prot before prog", prot, 1'b0);
      wr(17'h00300, 8'h11, 1'b0, 1, "R6");
      win_pulse();
      chk("R4", "prot before prog after window", prot, 1'b0);
      prog_pulse();
      chk("R4", "prot after prog", prot, 1'b1);

      // R5 / R10 protected ordinary writes
      wr(17'h00040, 8'h3C, 1'b0, 2, "R5");
      wr(17'h05555, 8'h12, 1'b0, 2, "R10");
      wr(17'h02AAA, 8'hAA, 1'b0, 2, "R10");

      // R11 persistence
      prog_pulse();
      prog_pulse();
      chk("R11", "prot", prot, 1'b1);

      // R6 unlocked window
      arm_seq("R3");
      for (int j = 0; j < 4; j++) wr(17'h00700 + 17'(j), 8'(8'hC0 + j), 1'b0, 1, "R6");
      win_pulse();
      wr(17'h00704, 8'h99, 1'b0, 2, "R6");
      prog_pulse();
      chk("R11", "prot after re-arm", prot, 1'b1);

      // R8 abort after every prefix
      for (int p = 1; p < 3; p++) begin
         for (int k = 0; k < p; k++) wr(arm_a[k], arm_d[k], 1'b0, 0, "R8");
         wr(17'h00123, 8'h33, 1'b0, 2, "R8");
         for (int k = p; k < 3; k++) wr(arm_a[k], arm_d[k], 1'b0, 2, "R8");
         wr(17'h00124, 8'h34, 1'b0, 2, "R8");
         win_pulse();
      end

      // R9 window end mid-sequence
      wr(arm_a[0], arm_d[0], 1'b0, 0, "R9");
      wr(arm_a[1], arm_d[1], 1'b0, 0, "R9");
      win_pulse();
      wr(arm_a[2], arm_d[2], 1'b0, 2, "R9");
      wr(arm_a[0], arm_d[0], 1'b0, 0, "R9");
      wr(arm_a[1], arm_d[1], 1'b0, 0, "R9");
      wr(arm_a[0], arm_d[0], 1'b1, 0, "R9");
      wr(arm_a[1], arm_d[1], 1'b0, 0, "R9");
      wr(arm_a[2], arm_d[2], 1'b0, 0, "R9");
      wr(17'h00800, 8'h5A, 1'b0, 1, "R9");
      win_pulse();
      prog_pulse();

      // R7 disarm
      for (int k = 0; k < 6; k++) wr(dis_a[k], dis_d[k], 1'b0, 0, "R7");
      chk("R7", "prot before prog", prot, 1'b1);
      wr(17'h00900, 8'h66, 1'b0, 1, "R7");
      win_pulse();
      prog_pulse();
      chk("R7", "prot after prog", prot, 1'b0);
      wr(17'h00901, 8'h67, 1'b0, 1, "R7");
      prog_pulse();
      chk("R12", "prot stays off", prot, 1'b0);

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=timeout expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule